// File: doc/BRIEF.md
# RTC Prescaler Frequency Corrector

This block trims the effective rate of a real-time-clock prescaler to make up for a source oscillator that runs slightly fast or slow. It does not hold the prescaler itself. Each source-clock cycle it tells the prescaler how far to step: hold, step by one, or step by two. Most cycles step by one. Once every `PERIOD_LEN` cycles there is a correction opportunity. In that cycle the step may be two, which adds a count for a slow oscillator, or zero, which skips a count for a fast one.

The cycle periods are grouped into frames of `FRAME_SLOTS` periods. A signed correction word is captured at the start of each frame. Its magnitude sets how many periods of that frame are corrected. The corrected periods are always the first ones in the frame. With the default sizes (1024 cycles per period, 976 periods per frame), each unit of magnitude shifts the rate by 10^6/(1024·976), which is about 1 ppm.

No correction is applied while the prescaler setting is 0 or 1. The surrounding logic uses this block by adding `incStep` to its prescaler on every source-clock edge.

Top module: `rtc_fcorr_top`

## Requirements
- R1: Counting source-clock edges from reset release as k = 0, 1, 2, …, `incStep` may differ from 1 only in a cycle with k mod `PERIOD_LEN` = `PERIOD_LEN`−1. Two adjustments are therefore never back to back.
- R2: `incStep` encodes the prescaler step as follows: 0 holds the prescaler, 1 advances it by one, 2 advances it by two. The value 3 never appears.
- R3: In the captured correction word, bit `MAG_W` is the sign and bits `MAG_W`−1..0 are the magnitude. Sign 0 gives step 2 in a corrected cycle (a count is added). Sign 1 gives step 0 (a count is skipped).
- R4: Within a frame, period number p (p = (k / `PERIOD_LEN`) mod `FRAME_SLOTS`) is corrected exactly when p < magnitude. So each frame carries min(magnitude, `FRAME_SLOTS`) adjustments, all in its first periods.
- R5: A correction is applied only if `prescSel` is greater than 1 in the correction cycle itself. Otherwise the step in that cycle is 1.
- R6: A magnitude of zero applies no correction in the frame, whatever the sign.
- R7: `corrValue` is sampled only in the first cycle of each frame (k mod (`PERIOD_LEN`·`FRAME_SLOTS`) = 0). Changes at any other time have no effect until the next frame starts.
- R8: While `rstN` is low, `incStep` is 1. Reset restarts the period and frame count from k = 0 and clears the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock of the prescaler |
| rstN | input | 1 | Asynchronous active-low reset |
| corrValue | input | MAG_W+1 | Signed correction: sign in the top bit, magnitude below |
| prescSel | input | SEL_W | Prescaler setting; correction is enabled above 1 |
| incStep | output | 2 | Prescaler step for this cycle: 0, 1 or 2 |

## Verification
The only output of the corrector is a step code, so every fault in its internal state appears as an adjustment in the wrong cycle, with the wrong direction, or missing entirely. A period counter that is out of phase shows within one period, because the adjustment no longer lands on the last cycle. A frame counter or captured word that is wrong shows within one frame, as a wrong number of adjustments or as adjustments outside the leading periods. The bench therefore compares the step in every cycle against its own model, and also counts the adds and skips in each frame.

// File: rtl/rtc_fcorr_pkg.sv
package rtc_fcorr_pkg;

  // Strobes from the sequencing control to the step datapath.
  typedef struct packed {
    logic corrSlot;   // this cycle is a correction opportunity that is due
    logic skipDir;    // 1: skip a count, 0: add a count
  } corrStrobe_t;

  typedef enum logic [1:0] {
    INC_HOLD   = 2'd0,
    INC_NORM   = 2'd1,
    INC_DOUBLE = 2'd2
  } incStep_e;

endpackage

// File: rtl/rtc_fcorr_ctrl.sv
module rtc_fcorr_ctrl
  import rtc_fcorr_pkg::*;
#(
  parameter int PERIOD_LEN  = 1024,
  parameter int FRAME_SLOTS = 976,
  parameter int MAG_W       = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MAG_W:0]     corrValue,
  output corrStrobe_t        strobe
);

  localparam int CYC_W  = (PERIOD_LEN  > 1) ? $clog2(PERIOD_LEN)  : 1;
  localparam int SLOT_W = (FRAME_SLOTS > 1) ? $clog2(FRAME_SLOTS) : 1;
  localparam int CMP_W  = ((SLOT_W > MAG_W) ? SLOT_W : MAG_W) + 1;

  logic [CYC_W-1:0]  cycCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic [MAG_W-1:0]  heldMag;
  logic              heldSign;
  logic              periodEnd;
  logic              frameLast;
  logic              frameStart;

  assign periodEnd  = (cycCnt == CYC_W'(PERIOD_LEN - 1));
  assign frameLast  = (slotCnt == SLOT_W'(FRAME_SLOTS - 1));
  assign frameStart = (cycCnt == '0) && (slotCnt == '0);

  // Period and frame position counters; word capture at frame start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt   <= '0;
      slotCnt  <= '0;
      heldMag  <= '0;
      heldSign <= 1'b0;
    end else begin
      cycCnt <= periodEnd ? '0 : cycCnt + 1'b1;
      if (periodEnd) begin
        slotCnt <= frameLast ? '0 : slotCnt + 1'b1;
      end
      if (frameStart) begin
        heldSign <= corrValue[MAG_W];
        heldMag  <= corrValue[MAG_W-1:0];
      end
    end
  end

  // Leading periods of the frame are the corrected ones.
  always_comb begin
    strobe.corrSlot = periodEnd && (CMP_W'(slotCnt) < CMP_W'(heldMag));
    strobe.skipDir  = heldSign;
  end

  AST_ZERO_MAG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (heldMag == '0) |-> !strobe.corrSlot); // R6

  AST_WORD_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(heldMag) && $stable(heldSign))); // R7

endmodule

// File: rtl/rtc_fcorr_dp.sv
module rtc_fcorr_dp
  import rtc_fcorr_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  corrStrobe_t      strobe,
  input  logic [SEL_W-1:0] prescSel,
  output incStep_e         incStep
);

  logic corrEnable;

  assign corrEnable = (prescSel > SEL_W'(1));

  always_comb begin
    incStep = INC_NORM;
    if (strobe.corrSlot && corrEnable) begin
      incStep = strobe.skipDir ? INC_HOLD : INC_DOUBLE;
    end
  end

  AST_LOW_SETTING_NO_ADJUST: assert property (@(posedge clk) disable iff (!rstN)
    (prescSel <= SEL_W'(1)) |-> (incStep == INC_NORM)); // R5

  AST_IDLE_STEP_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.corrSlot |-> (incStep == INC_NORM)); // R1

endmodule

// File: rtl/rtc_fcorr_top.sv
module rtc_fcorr_top
  import rtc_fcorr_pkg::*;
#(
  parameter int PERIOD_LEN  = 1024,
  parameter int FRAME_SLOTS = 976,
  parameter int MAG_W       = 7,
  parameter int SEL_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [MAG_W:0]   corrValue,
  input  logic [SEL_W-1:0] prescSel,
  output logic [1:0]       incStep
);

  corrStrobe_t strobe;
  incStep_e    stepCode;

  rtc_fcorr_ctrl #(
    .PERIOD_LEN (PERIOD_LEN),
    .FRAME_SLOTS(FRAME_SLOTS),
    .MAG_W      (MAG_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .corrValue(corrValue),
    .strobe   (strobe)
  );

  rtc_fcorr_dp #(
    .SEL_W(SEL_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .prescSel(prescSel),
    .incStep (stepCode)
  );

  assign incStep = stepCode;

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (incStep != 2'd1) |=> (incStep == 2'd1)); // R1

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    incStep != 2'd3); // R2

endmodule

// File: tb/rtc_fcorr_tb.sv
module rtc_fcorr_top_tb_top;

  localparam int P     = 16;
  localparam int S     = 10;
  localparam int F     = P * S;
  localparam int MAG_W = 7;
  localparam int SEL_W = 4;
  localparam int VEC_N = 9;

  // value, setting, expected adds and skips per frame
  localparam int VEC_VAL [VEC_N] = '{8'h03, 8'h83, 8'h00, 8'h0A, 8'h0F, 8'h85, 8'h05, 8'h81, 8'h8A};
  localparam int VEC_SEL [VEC_N] = '{2, 2, 5, 2, 3, 1, 0, 15, 2};
  localparam int VEC_ADD [VEC_N] = '{3, 0, 0, 10, 10, 0, 0, 0, 0};
  localparam int VEC_SKP [VEC_N] = '{0, 3, 0, 0, 0, 0, 0, 1, 10};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [MAG_W:0]   corrValue = '0;
  logic [SEL_W-1:0] prescSel = '0;
  logic [1:0]       incStep;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  bit done   = 1'b0;

  always #4ns clk = ~clk;

  rtc_fcorr_top #(
    .PERIOD_LEN (P),
    .FRAME_SLOTS(S),
    .MAG_W      (MAG_W),
    .SEL_W      (SEL_W)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .corrValue(corrValue),
    .prescSel (prescSel),
    .incStep  (incStep)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (k=%0d)", tag, act, exp, k);
    end
  endtask

  // Entered at the negedge of a frame's first cycle (k mod F == 0).
  task automatic runFrame(input int val, input int sel, input int dropSlot,
                          input int expAdd, input int expSkip, input string tag);
    int adds = 0;
    int skips = 0;
    int mag = val & 8'h7F;
    int lim = (mag < S) ? mag : S;
    bit neg = (val & 8'h80) != 0;
    corrValue = 8'(val);
    prescSel  = 4'(sel);
    for (int i = 1; i <= F; i++) begin
      int kk;
      int exp;
      @(posedge clk);
      k++;
      @(negedge clk);
      kk = k % F;
      exp = 1;
      if (i < F && (kk % P) == P - 1 && (kk / P) < lim && prescSel > 1)
        exp = neg ? 0 : 2;
      check(int'(incStep), exp, "R1 R2 R3 R4 step");
      if (i < F) begin
        if (incStep == 2'd2) adds++;
        if (incStep == 2'd0) skips++;
      end
      if (i == F / 2) corrValue = ~corrValue;  // mid-frame change ignored
      if (dropSlot >= 0 && ((k + 1) % F) == dropSlot * P + P - 1)
        prescSel = 4'd1;
      else
        prescSel = 4'(sel);
    end
    check(adds, expAdd, {tag, " adds"});
    check(skips, expSkip, {tag, " skips"});
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    corrValue = 8'h03;
    prescSel  = 4'd2;
    repeat (3) @(negedge clk);
    check(int'(incStep), 1, "R8 step in reset");
    rstN = 1'b1;
    k = 0;
    check(int'(incStep), 1, "R8 step after release");

    for (int v = 0; v < VEC_N; v++)
      runFrame(VEC_VAL[v], VEC_SEL[v], -1, VEC_ADD[v], VEC_SKP[v], "R4 R5 R6 R7 vector");

    // R5: setting drops to 1 only in slot 1's correction cycle
    runFrame(8'h03, 2, 1, 2, 0, "R5 live setting");

    // R8: reset mid-frame restarts the count and clears the word
    repeat (P * 3 + 5) begin
      @(posedge clk);
      k++;
    end
    @(negedge clk);
    rstN = 1'b0;
    corrValue = 8'h02;
    prescSel = 4'd2;
    @(negedge clk);
    check(int'(incStep), 1, "R8 step in reset mid-frame");
    rstN = 1'b1;
    k = 0;
    runFrame(8'h02, 2, -1, 2, 0, "R8 restart");
    runFrame(8'h80, 2, -1, 0, 0, "R6 negative zero");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule